// File: doc/BRIEF.md
# Watchdog Timer with Prescaler

This block watches for a stalled program. It advances a counter on a free-running watchdog clock enable that is independent of the main system clock, so the watchdog keeps counting while the rest of the device sleeps. If software does not strobe the clear input within the programmed period, the block acts. When the device is running, it issues a single-cycle reset request. When the device is asleep, it issues a single-cycle wake request instead, and the device resumes without a reset.

A power-of-two prescaler can be placed in front of the counter through a software-written option field. This stretches the period from the base tick count, which models a nominal 18 ms interval, up to 128 times that count. An active-high status flag drops to 0 on every timeout. Software can read the flag after start-up to tell a watchdog event from a normal start.

The control is a four-state machine. **OFF** is held while the static enable fuse is 0 and returns to **COUNT** once the fuse is 1. **COUNT** goes to **RESET_PULSE** on a timeout while awake, and to **WAKE_PULSE** on a timeout while asleep. Both pulse states return to **COUNT** after one cycle, or to **OFF** if the fuse is 0. A timeout reloads the counter to zero, so the watchdog rearms without any software action.

Top module: `wdt_top`

## Requirements
- R1: After reset, `rst_req` and `wake_req` are 0 and `alive_flag` is 1.
- R2: With `pre_to_wdt` = 0, a timeout occurs on the BASE_TICKS-th cycle with `wdt_tick` = 1 since reset, the last clear or the last timeout. Cycles with `wdt_tick` = 0 do not advance the count.
- R3: With `pre_to_wdt` = 1, the ticks are divided by 2^`pre_ratio` (`pre_ratio` 0..7 gives 1:1 to 1:128). A timeout then takes BASE_TICKS * 2^`pre_ratio` ticks after a clear.
- R4: A `clr_wdt` strobe zeroes the counter and the prescaler. A tick in the same cycle as the strobe is discarded.
- R5: A `sleep_enter` strobe zeroes the counter and the prescaler in the same way as `clr_wdt`.
- R6: A timeout with `sleep_mode` = 0 makes `rst_req` high for exactly one cycle, the cycle after the final tick, and leaves `wake_req` at 0.
- R7: A timeout with `sleep_mode` = 1 makes `wake_req` high for exactly one cycle, the cycle after the final tick, and leaves `rst_req` at 0.
- R8: `alive_flag` goes to 0 on a timeout and returns to 1 after a `clr_wdt` or `sleep_enter` strobe.
- R9: With `fuse_en` = 0, the block never counts and never produces `rst_req` or `wake_req`, whatever the ticks are.
- R10: A change of `pre_ratio` or `pre_to_wdt` zeroes the prescaler. A partial prescaler count is therefore not carried into the new ratio.
- R11: After a timeout, the counter restarts from zero on its own. The next timeout follows after a further full period with no clear strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| wdt_tick | input | 1 | Free-running watchdog clock enable |
| clr_wdt | input | 1 | Software clear-watchdog strobe |
| sleep_enter | input | 1 | Strobe issued on entry to sleep |
| sleep_mode | input | 1 | 1 while the device is asleep |
| pre_to_wdt | input | 1 | 1 assigns the prescaler to the watchdog |
| pre_ratio | input | RATIO_W | Prescaler exponent n, divide by 2^n |
| fuse_en | input | 1 | Static watchdog enable fuse |
| rst_req | output | 1 | One-cycle device reset request |
| wake_req | output | 1 | One-cycle wake-from-sleep request |
| alive_flag | output | 1 | 1 until a timeout occurs, restored by a strobe |

## Verification
The bench builds the block with BASE_TICKS = 4 and the default 3-bit ratio field. With these values the full 1:128 divide times out after 512 ticks, so every prescaler setting, auto-reload and back-to-back timeouts fit into a short run. The bench checks ratio changes in the middle of a count, a clear that coincides with the final tick, and idle gaps between ticks by exact cycle of the resulting pulse. A second reset with the fuse at 0 checks that hundreds of ticks produce nothing.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // Control states of the watchdog sequencer
    typedef enum logic [1:0] {
        WS_OFF   = 2'd0,
        WS_COUNT = 2'd1,
        WS_RESET = 2'd2,
        WS_WAKE  = 2'd3
    } wdt_state_e;

endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
    parameter int RATIO_W = 3,
    parameter int PRE_W   = (1 << RATIO_W) - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               tick_in,
    input  logic               assign_in,
    input  logic [RATIO_W-1:0] ratio_in,
    input  logic               clr,
    output logic               tick_out
);

    logic [PRE_W-1:0]   pre_cnt;
    logic [RATIO_W-1:0] ratio_q;
    logic               assign_q;
    logic               cfg_chg;
    logic [PRE_W:0]     span;
    logic [PRE_W-1:0]   limit;
    logic               wrap;

    // Divide limit 2^n - 1 computed from the exponent
    assign span    = ({{PRE_W{1'b0}}, 1'b1} << ratio_in) - {{PRE_W{1'b0}}, 1'b1};
    assign limit   = span[PRE_W-1:0];
    assign cfg_chg = (ratio_in != ratio_q) || (assign_in != assign_q);
    assign wrap    = (pre_cnt == limit);

    assign tick_out = en && tick_in && !clr &&
                      (!assign_in || (!cfg_chg && wrap));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ratio_q  <= '0;
            assign_q <= 1'b0;
        end else begin
            ratio_q  <= ratio_in;
            assign_q <= assign_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt <= '0;
        end else if (!en || !assign_in || clr || cfg_chg) begin
            pre_cnt <= '0;
        end else if (tick_in) begin
            pre_cnt <= wrap ? '0 : pre_cnt + 1'b1;
        end
    end

    AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (en && assign_in && !cfg_chg) |-> (pre_cnt <= limit)) else $error("prescaler above limit"); // R3

    AST_PRE_CFG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (en && assign_in && cfg_chg) |=> (pre_cnt == '0)) else $error("prescaler kept count over change"); // R10

endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
    parameter int BASE_TICKS = 18000,
    parameter int CNT_W      = (BASE_TICKS > 2) ? $clog2(BASE_TICKS) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic step,
    input  logic clr,
    output logic expire
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(BASE_TICKS - 1);

    logic [CNT_W-1:0] cnt;

    assign expire = en && step && !clr && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en || clr || expire) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST) else $error("watchdog count out of range"); // R2

    AST_NO_EXPIRE_AFTER_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr) |-> !expire) else $error("expiry right after clear"); // R4

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clr && en) |=> $stable(cnt)) else $error("count moved without tick"); // R2

endmodule

// File: rtl/wdt_fsm.sv
module wdt_fsm
    import wdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic expire,
    input  logic clr,
    input  logic asleep,
    output logic rst_req,
    output logic wake_req,
    output logic alive
);

    wdt_state_e state, state_nx;

    // Next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            WS_OFF:   state_nx = en ? WS_COUNT : WS_OFF;
            WS_COUNT: begin
                if (!en)          state_nx = WS_OFF;
                else if (expire)  state_nx = asleep ? WS_WAKE : WS_RESET;
                else              state_nx = WS_COUNT;
            end
            WS_RESET: state_nx = en ? WS_COUNT : WS_OFF;
            WS_WAKE:  state_nx = en ? WS_COUNT : WS_OFF;
            default:  state_nx = WS_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= WS_COUNT;
        else        state <= state_nx;
    end

    // Moore outputs
    always_comb begin
        rst_req  = 1'b0;
        wake_req = 1'b0;
        unique case (state)
            WS_OFF:   ;
            WS_COUNT: ;
            WS_RESET: rst_req  = 1'b1;
            WS_WAKE:  wake_req = 1'b1;
            default:  ;
        endcase
    end

    // Sticky status: low after a timeout, restored by a strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      alive <= 1'b1;
        else if (clr)    alive <= 1'b1;
        else if (expire) alive <= 1'b0;
    end

    AST_NO_DUAL_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_req && wake_req)) else $error("reset and wake together"); // R6

    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req) else $error("reset request longer than one cycle"); // R6

    AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |=> !wake_req) else $error("wake request longer than one cycle"); // R7

    AST_FLAG_LOW_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req || wake_req) |-> !alive) else $error("status high during timeout pulse"); // R8

    AST_FUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !(rst_req || wake_req)) else $error("request with fuse off"); // R9

endmodule

// File: rtl/wdt_top.sv
module wdt_top #(
    parameter int BASE_TICKS    = 18000,
    parameter int RATIO_W       = 3,
    parameter bit USE_PRESCALER = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wdt_tick,
    input  logic               clr_wdt,
    input  logic               sleep_enter,
    input  logic               sleep_mode,
    input  logic               pre_to_wdt,
    input  logic [RATIO_W-1:0] pre_ratio,
    input  logic               fuse_en,
    output logic               rst_req,
    output logic               wake_req,
    output logic               alive_flag
);

    localparam int PRE_W = (1 << RATIO_W) - 1;

    logic clr_any;
    logic step;
    logic expire;

    assign clr_any = clr_wdt | sleep_enter;

    generate
        if (USE_PRESCALER) begin : g_pre
            wdt_prescale #(
                .RATIO_W (RATIO_W),
                .PRE_W   (PRE_W)
            ) u_pre (
                .clk       (clk),
                .rst_n     (rst_n),
                .en        (fuse_en),
                .tick_in   (wdt_tick),
                .assign_in (pre_to_wdt),
                .ratio_in  (pre_ratio),
                .clr       (clr_any),
                .tick_out  (step)
            );
        end else begin : g_direct
            assign step = fuse_en && wdt_tick && !clr_any;
        end
    endgenerate

    wdt_count #(
        .BASE_TICKS (BASE_TICKS)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (fuse_en),
        .step   (step),
        .clr    (clr_any),
        .expire (expire)
    );

    wdt_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (fuse_en),
        .expire   (expire),
        .clr      (clr_any),
        .asleep   (sleep_mode),
        .rst_req  (rst_req),
        .wake_req (wake_req),
        .alive    (alive_flag)
    );

    AST_STROBE_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_any |=> alive_flag) else $error("status not restored by strobe"); // R8

endmodule

// File: tb/sim_wdt_top.sv
module sim_wdt_top;

    localparam int B  = 4;
    localparam int RW = 3;
    localparam int K_RST  = 0;
    localparam int K_WAKE = 1;

    typedef struct {
        int    kind;
        int    cyc;
        string req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wdt_tick = 1'b0;
    logic          clr_wdt = 1'b0;
    logic          sleep_enter = 1'b0;
    logic          sleep_mode = 1'b0;
    logic          pre_to_wdt = 1'b0;
    logic [RW-1:0] pre_ratio = '0;
    logic          fuse_en = 1'b1;
    logic          rst_req;
    logic          wake_req;
    logic          alive_flag;

    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    exp_t sb[$];

    wdt_top #(.BASE_TICKS(B), .RATIO_W(RW), .USE_PRESCALER(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .wdt_tick(wdt_tick), .clr_wdt(clr_wdt),
        .sleep_enter(sleep_enter), .sleep_mode(sleep_mode), .pre_to_wdt(pre_to_wdt),
        .pre_ratio(pre_ratio), .fuse_en(fuse_en), .rst_req(rst_req),
        .wake_req(wake_req), .alive_flag(alive_flag)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: every pulse must match the next queued expectation
    always @(posedge clk) begin
        #1;
        if (rst_n && (rst_req || wake_req)) begin
            if (sb.size() == 0) begin
                check(1'b0, "R6/R7/R9", "unexpected pulse at cycle", cyc, -1);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(rst_req == (e.kind == K_RST) && wake_req == (e.kind == K_WAKE),
                      e.req, "pulse kind (rst,wake)", {rst_req, wake_req},
                      (e.kind == K_RST) ? 2 : 1);
                check(cyc == e.cyc, e.req, "pulse cycle", cyc, e.cyc);
            end
        end
    end

    // Driver: n ticks, each after gap idle cycles; last tick may push an expectation
    task automatic ticks(input int n, input int gap, input int kind, input string req);
        for (int i = 0; i < n; i++) begin
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                wdt_tick = 1'b0;
            end
            @(negedge clk);
            wdt_tick = 1'b1;
            if (i == n - 1 && kind >= 0) begin
                exp_t e;
                e.kind = kind;
                e.cyc  = cyc + 1;
                e.req  = req;
                sb.push_back(e);
            end
        end
        @(negedge clk);
        wdt_tick = 1'b0;
    endtask

    task automatic strobe_clr(input bit with_tick);
        @(negedge clk);
        clr_wdt  = 1'b1;
        wdt_tick = with_tick;
        @(negedge clk);
        clr_wdt  = 1'b0;
        wdt_tick = 1'b0;
    endtask

    task automatic strobe_sleep();
        @(negedge clk);
        sleep_enter = 1'b1;
        @(negedge clk);
        sleep_enter = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(rst_req == 1'b0, "R1", "rst_req after reset", rst_req, 0);
        check(wake_req == 1'b0, "R1", "wake_req after reset", wake_req, 0);
        check(alive_flag == 1'b1, "R1", "alive_flag after reset", alive_flag, 1);

        // R2 R6: base period with no prescaler
        ticks(B, 0, K_RST, "R2/R6");
        check(alive_flag == 1'b0, "R8", "flag after timeout", alive_flag, 0);

        // R11: auto reload, ticks separated by idle cycles
        ticks(B, 2, K_RST, "R11");

        // R8: strobe restores flag
        strobe_clr(1'b0);
        check(alive_flag == 1'b1, "R8", "flag after clear", alive_flag, 1);

        // R4: clear in mid-count restarts the period
        ticks(B - 1, 0, -1, "");
        strobe_clr(1'b0);
        ticks(B - 1, 0, -1, "");
        ticks(1, 0, K_RST, "R4");

        // R4: clear coinciding with the final tick wins
        ticks(B - 1, 0, -1, "");
        strobe_clr(1'b1);
        ticks(B - 1, 0, -1, "");
        ticks(1, 0, K_RST, "R4 coincident");

        // R3: several prescaler ratios
        for (int k = 0; k < 3; k++) begin
            int n;
            n = (k == 0) ? 1 : (k == 1) ? 3 : 7;
            @(negedge clk);
            pre_to_wdt = 1'b1;
            pre_ratio  = RW'(n);
            strobe_clr(1'b0);
            ticks(B * (1 << n) - 1, 0, -1, "");
            ticks(1, 0, K_RST, "R3");
        end

        // R10: ratio change drops partial prescaler count
        @(negedge clk);
        pre_ratio = RW'(2);
        strobe_clr(1'b0);
        ticks(2, 0, -1, "");
        @(negedge clk);
        pre_ratio = RW'(1);
        ticks(2 * B - 1, 0, -1, "");
        ticks(1, 0, K_RST, "R10");

        // R5 R7: sleep strobe clears, timeout in sleep wakes
        @(negedge clk);
        pre_to_wdt = 1'b0;
        pre_ratio  = '0;
        sleep_mode = 1'b1;
        strobe_sleep();
        check(alive_flag == 1'b1, "R8", "flag after sleep strobe", alive_flag, 1);
        ticks(B - 1, 0, -1, "");
        strobe_sleep();
        ticks(B - 1, 0, -1, "");
        ticks(1, 0, K_WAKE, "R5/R7");
        check(alive_flag == 1'b0, "R8", "flag after wake timeout", alive_flag, 0);
        @(negedge clk);
        sleep_mode = 1'b0;
        check(sb.size() == 0, "R2", "pending expected pulses", sb.size(), 0);

        // R9: fuse off, nothing happens
        @(negedge clk);
        rst_n   = 1'b0;
        fuse_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        ticks(600, 0, -1, "");
        check(alive_flag == 1'b1, "R9", "flag with fuse off", alive_flag, 1);
        check(rst_req == 1'b0 && wake_req == 1'b0, "R9", "requests with fuse off",
              {rst_req, wake_req}, 0);
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule